// File: doc/BRIEF.md
# Two-Level Interrupt Status Aggregator

This block gathers interrupt requests from two kinds of requesters into one status word and drives a single interrupt line toward the host processor. The first kind is four GPIO banks. Each bank presents one summary request that is already masked and cleared inside the bank. The second kind is six other peripherals, and each of those presents a level request. The status word places the bank summaries in its low group of bits and the peripheral requests in its high group. The host reads this word to decide which bank or peripheral to service.

An enable register gates what reaches the host. It holds one enable bit for each peripheral source, where a 1 lets the source through, and one global enable bit that must be set before anything can raise the line. Bank summaries are not gated per bit here, because their masking lives in the banks. The host treats the line as edge-triggered. The line therefore drops for at least one cycle whenever nothing eligible is pending, so the next request produces a fresh rising edge.

Top module: `irq_status_agg`

## Requirements
- R1: While reset is held and on release, status_o is all zero, mask_o is all zero and host_irq_o is low.
- R2: status_o bits 0..3 copy bank_irq_i bits 0..3 (bank A at bit 0), one clock after the inputs are sampled; the bank bits are read-only mirrors.
- R3: status_o bits 4..9 copy src_irq_i bits 0..5 in order (source k at status bit 4+k), one clock after sampling, whatever the enable register holds.
- R4: A clock edge with mask_we_i high loads mask_wdata_i into the enable register, visible on mask_o from the next cycle; bits 0..5 enable sources 0..5 (1 = enabled) and bit 6 is the global enable.
- R5: While the global enable bit (mask bit 6) is clear, host_irq_o stays low for any request pattern.
- R6: host_irq_o is high one clock after the global enable is set and the status word holds a set bank bit or a set source bit whose enable is 1.
- R7: A source whose enable bit is 0 never raises host_irq_o on its own, although its status bit still reads 1.
- R8: One clock after the status word has no eligible bit, host_irq_o is low, and it stays low for at least one cycle before a later request raises it again with a new rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_irq_i | input | 4 | Summary request from each GPIO bank, bank A at bit 0 |
| src_irq_i | input | 6 | Level request from each non-GPIO source |
| mask_we_i | input | 1 | Write strobe for the enable register |
| mask_wdata_i | input | 7 | New enable value: bits 0..5 source enables, bit 6 global enable |
| status_o | output | 10 | Status word: bits 0..3 bank summaries, bits 4..9 sources |
| mask_o | output | 7 | Current enable register |
| host_irq_o | output | 1 | Interrupt line to the host, registered |

## Verification
The assertions assume that every request input is synchronous to clk and that each input is either held or changed cleanly at a clock edge. They also assume the enable register changes only through the write strobe. The bench drives all inputs on the falling edge, so every rising edge sees stable values. Random request patterns and occasional random enable writes are mixed with directed runs. The directed runs hold the global enable off, leave a disabled source requesting alone, and take the pending set through empty and back, so that every assertion is exercised under legal stimulus.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned BANKS_DEF = 4;
  localparam int unsigned SRCS_DEF  = 6;

  // Bank-group bits are always eligible; source bits need their enable.
  function automatic logic bank_group_active(input logic [31:0] bank_bits);
    return |bank_bits;
  endfunction

  function automatic logic src_group_active(input logic [31:0] src_bits,
                                            input logic [31:0] src_en);
    return |(src_bits & src_en);
  endfunction

  function automatic logic line_request(input logic [31:0] bank_bits,
                                        input logic [31:0] src_bits,
                                        input logic [31:0] src_en,
                                        input logic        glob_en);
    return glob_en & (bank_group_active(bank_bits) |
                      src_group_active(src_bits, src_en));
  endfunction
endpackage

// File: rtl/irq_status_capture.sv
module irq_status_capture #(
  parameter int unsigned NB = 4,
  parameter int unsigned NS = 6,
  localparam int unsigned STW = NB + NS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NB-1:0]  bank_i,
  input  logic [NS-1:0]  src_i,
  output logic [STW-1:0] status_o
);
  // Low group: one flop per bank summary.
  for (genvar b = 0; b < NB; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_o[b] <= 1'b0;
      else        status_o[b] <= bank_i[b];
    end
  end

  // High group: one flop per level source, in source order.
  for (genvar s = 0; s < NS; s++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_o[NB+s] <= 1'b0;
      else        status_o[NB+s] <= src_i[s];
    end
  end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int unsigned NS = 6,
  localparam int unsigned MW = NS + 1,
  localparam int unsigned GEN_BIT = NS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [MW-1:0] wdata_i,
  output logic [MW-1:0] mask_o,
  output logic [NS-1:0] src_en_o,
  output logic          glob_en_o
);
  logic [MW-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q <= '0;
    else if (we_i) mask_q <= wdata_i;
  end

  assign mask_o    = mask_q;
  assign src_en_o  = mask_q[NS-1:0];
  assign glob_en_o = mask_q[GEN_BIT];
endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen
  import irq_agg_pkg::*;
#(
  parameter int unsigned NB = 4,
  parameter int unsigned NS = 6,
  localparam int unsigned STW = NB + NS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [STW-1:0] status_i,
  input  logic [NS-1:0]  src_en_i,
  input  logic           glob_en_i,
  output logic           pending_o,
  output logic           irq_o
);
  logic [31:0] bank_bits, src_bits, en_bits;
  logic [NS-1:0] src_eligible;

  always_comb begin
    bank_bits = '0;
    src_bits  = '0;
    en_bits   = '0;
    bank_bits[NB-1:0] = status_i[NB-1:0];
    src_bits[NS-1:0]  = status_i[STW-1:NB];
    en_bits[NS-1:0]   = src_en_i;
  end

  for (genvar s = 0; s < NS; s++) begin : g_elig
    assign src_eligible[s] = status_i[NB+s] & src_en_i[s];
  end

  assign pending_o = line_request(bank_bits, src_bits, en_bits, glob_en_i);

  // Registered line: drops the cycle after pending empties, giving a
  // fresh rising edge for the next request.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= pending_o;
  end

  // R5
  glob_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(glob_en_i) |-> !irq_o);

  // R6
  raise_on_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(glob_en_i) && ($past(|status_i[NB-1:0]) || $past(|src_eligible)))
      |-> irq_o);

  // R7
  disabled_src_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status_i[NB-1:0] == '0) && $past(src_eligible == '0)) |-> !irq_o);

  // R8
  empty_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(status_i == '0) |-> !irq_o);
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned NB = BANKS_DEF,
  parameter int unsigned NS = SRCS_DEF,
  localparam int unsigned STW = NB + NS,
  localparam int unsigned MW  = NS + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NB-1:0]  bank_irq_i,
  input  logic [NS-1:0]  src_irq_i,
  input  logic           mask_we_i,
  input  logic [MW-1:0]  mask_wdata_i,
  output logic [STW-1:0] status_o,
  output logic [MW-1:0]  mask_o,
  output logic           host_irq_o
);
  logic [STW-1:0] status_w;
  logic [NS-1:0]  src_en_w;
  logic           glob_en_w;
  logic           pending_w;

  irq_status_capture #(.NB(NB), .NS(NS)) u_cap (
    .clk(clk), .rst_n(rst_n), .bank_i(bank_irq_i), .src_i(src_irq_i),
    .status_o(status_w));

  irq_enable_reg #(.NS(NS)) u_en (
    .clk(clk), .rst_n(rst_n), .we_i(mask_we_i), .wdata_i(mask_wdata_i),
    .mask_o(mask_o), .src_en_o(src_en_w), .glob_en_o(glob_en_w));

  irq_line_gen #(.NB(NB), .NS(NS)) u_line (
    .clk(clk), .rst_n(rst_n), .status_i(status_w), .src_en_i(src_en_w),
    .glob_en_i(glob_en_w), .pending_o(pending_w), .irq_o(host_irq_o));

  assign status_o = status_w;

  // R4
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mask_we_i) |-> (mask_o == $past(mask_wdata_i)));

  // R2
  bank_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[NB-1:0] == $past(bank_irq_i));
endmodule

// File: tb/irq_status_agg_tb.sv
module irq_status_agg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int NS = 6;

  logic clk = 0;
  logic rst_n = 0;
  logic [NB-1:0] bank_irq = '0;
  logic [NS-1:0] src_irq = '0;
  logic mask_we = 0;
  logic [NS:0] mask_wdata = '0;
  logic [NB+NS-1:0] status;
  logic [NS:0] mask;
  logic host_irq;

  int tests = 0;
  int fails = 0;

  logic [NB+NS-1:0] exp_status = '0;
  logic [NS:0] exp_mask = '0;
  logic exp_irq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_agg u_dut (
    .clk(clk), .rst_n(rst_n), .bank_irq_i(bank_irq), .src_irq_i(src_irq),
    .mask_we_i(mask_we), .mask_wdata_i(mask_wdata), .status_o(status),
    .mask_o(mask), .host_irq_o(host_irq));

  // Bit-by-bit restatement of the eligibility rule.
  function automatic logic model_line(input logic [NB+NS-1:0] st,
                                      input logic [NS:0] m);
    logic hit = 0;
    for (int i = 0; i < NB + NS; i++) begin
      if (st[i]) begin
        if (i < NB) hit = 1;
        else if (m[i-NB]) hit = 1;
      end
    end
    return hit && m[NS];
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive at negedge, let one rising edge pass, check at the next negedge.
  task automatic step(input logic [NB-1:0] b, input logic [NS-1:0] s,
                      input logic we, input logic [NS:0] wd);
    logic nirq;
    bank_irq = b; src_irq = s; mask_we = we; mask_wdata = wd;
    @(negedge clk);
    nirq = model_line(exp_status, exp_mask);
    exp_status = {s, b};
    if (we) exp_mask = wd;
    exp_irq = nirq;
    check("R2 bank bits", 32'(status[NB-1:0]), 32'(exp_status[NB-1:0]));
    check("R3 source bits", 32'(status[NB+NS-1:NB]), 32'(exp_status[NB+NS-1:NB]));
    check("R4 mask", 32'(mask), 32'(exp_mask));
    check("R6 line", 32'(host_irq), 32'(exp_irq));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int rises;
    logic prev;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 status", 32'(status), 0);
    check("R1 mask", 32'(mask), 0);
    check("R1 line", 32'(host_irq), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 line after release", 32'(host_irq), 0);

    // R5: global off, everything requesting
    step('1, '1, 1, 7'h3F);
    for (int i = 0; i < 5; i++) begin
      step('1, '1, 0, '0);
      check("R5 global off", 32'(host_irq), 0);
    end

    // R7: global on, source 2 disabled and alone
    step('0, 6'b000100, 1, 7'b1111011);
    for (int i = 0; i < 4; i++) begin
      step('0, 6'b000100, 0, '0);
      check("R7 disabled source quiet", 32'(host_irq), 0);
      check("R7 status still set", 32'(status[NB+2]), 1);
    end
    // Same source enabled: line rises
    step('0, 6'b000100, 1, 7'h7F);
    step('0, 6'b000100, 0, '0);
    check("R6 enabled source raises", 32'(host_irq), 1);

    // R8: pending, empty one cycle, pending again -> two rising edges
    rises = 0; prev = host_irq;
    step(4'b0001, '0, 0, '0);
    step('0, '0, 0, '0);
    step('0, '0, 0, '0);
    check("R8 low after empty", 32'(host_irq), 0);
    prev = host_irq;
    step(4'b1000, '0, 0, '0);
    step(4'b1000, '0, 0, '0);
    if (!prev && host_irq) rises++;
    check("R8 new rising edge", 32'(rises), 1);
    step('0, '0, 0, '0);
    step(4'b0010, '0, 0, '0);
    check("R8 one-cycle low gap", 32'(host_irq), 0);
    step(4'b0010, '0, 0, '0);
    check("R8 raised again", 32'(host_irq), 1);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [NB-1:0] b;
      logic [NS-1:0] s;
      logic we;
      logic [NS:0] wd;
      b  = ($urandom % 4 == 0) ? NB'($urandom) : '0;
      s  = ($urandom % 3 == 0) ? NS'($urandom) : '0;
      we = ($urandom % 8 == 0);
      wd = (NS+1)'($urandom);
      step(b, s, we, wd);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule